// File: doc/BRIEF.md
# Serial Stereo Audio Word Receiver

This block turns a three-wire serial stereo audio stream into parallel samples for the filter datapath. A bit clock, a data line and a word clock arrive from outside the chip. All three are brought into the system-clock domain through two-flop synchronisers, and their edges are detected there. Each data bit is shifted in on a rising bit-clock edge. The word gathered so far is committed to one of two 16-bit output registers whenever the word clock changes level, in either direction.

The word-clock level just before the change decides the destination. A high level means the first channel and a low level means the second. Every commit raises a one-cycle valid strobe for that channel only. The active-low initialise input clears the block asynchronously. Its release is synchronised to the system clock, and the line levels present at release are not mistaken for edges. A standard/double-speed select is passed straight through to the downstream blocks. It does not change the framing, which only requires the system clock to run at least four times the bit-clock rate.

Top module: `serial_audio_rx`

## Requirements
- R1: A sample is 16 bits in two's complement with the most significant bit sent first. The first bit of a 16-bit run ends up at bit 15 of the committed word and the last at bit 0.
- R2: Data is taken only on a rising bit-clock edge. Changes on the data line while the bit clock is high or falling have no effect on the word.
- R3: Every word-clock transition, rising or falling, commits the shifted word. A high word-clock level before the transition selects `ch1_word_o`; a low level selects `ch2_word_o`.
- R4: A commit raises the valid strobe of the selected channel for exactly one system-clock cycle, and never both strobes together. The strobe and the new word appear 3 system-clock edges after the word-clock change reaches the input.
- R5: The output word of the channel that is not selected keeps its value across a commit.
- R6: When more than 16 bits arrive between word-clock edges, only the last 16 bits before the edge are committed.
- R7: While `init_n` is low, both words are all-zero, no strobe is raised, line activity is ignored and the partially shifted word is cleared. The clearing takes effect without waiting for a clock edge.
- R8: After `init_n` is released, the line levels present at release are taken as the starting levels. A word clock already high at release produces no commit.
- R9: `dbl_speed_o` always equals `dbl_speed_i`. Framing and results are the same in both modes at the faster line rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock used to resample the serial lines |
| init_n | input | 1 | Active-low initialise, asynchronous assertion |
| bclk_i | input | 1 | Serial bit clock |
| data_i | input | 1 | Serial data, MSB first |
| lrck_i | input | 1 | Word clock, high = channel 1 |
| dbl_speed_i | input | 1 | Standard (0) / double-speed (1) select |
| ch1_word_o | output | 16 | Last committed channel-1 sample |
| ch1_valid_o | output | 1 | One-cycle strobe on a channel-1 commit |
| ch2_word_o | output | 16 | Last committed channel-2 sample |
| ch2_valid_o | output | 1 | One-cycle strobe on a channel-2 commit |
| dbl_speed_o | output | 1 | Speed select passed to downstream blocks |

## Verification
Each line change has a latency of three system-clock edges: two synchroniser stages, then the output or shift register. The bench therefore drives every line on a falling system-clock edge and samples the strobe and word on the third falling edge after a word-clock change. On the fourth falling edge it checks that the strobe has dropped, and a strobe counter confirms that it was high for exactly one cycle. Bits are held for whole half-periods of the bit clock, so each shift completes long before the next word-clock change. The asynchronous clear under `init_n` is checked one nanosecond after assertion, with no clock edge in between.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned LINE_CNT = 3;
  localparam int unsigned L_BCLK   = 0;
  localparam int unsigned L_DATA   = 1;
  localparam int unsigned L_LRCK   = 2;

  typedef enum logic {
    CH_TWO = 1'b0,
    CH_ONE = 1'b1
  } chan_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_line_sync.sv
module sar_line_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev,
  output logic         armed
);
  localparam int unsigned ARM_LAST = STAGES + 1;
  localparam int unsigned ARM_W    = $clog2(ARM_LAST + 1);
  localparam logic [ARM_W-1:0] ARM_LAST_V = ARM_W'(ARM_LAST);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;
  logic [W-1:0]             prev_q;
  logic [ARM_W-1:0]         arm_cnt_q;
  logic [ARM_W-1:0]         arm_cnt_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = d;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_comb begin
    arm_cnt_d = arm_cnt_q;
    if (arm_cnt_q != ARM_LAST_V) arm_cnt_d = arm_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      stage_q   <= stage_d;
      prev_q    <= stage_q[STAGES-1];
      arm_cnt_q <= arm_cnt_d;
    end
  end

  assign q      = stage_q[STAGES-1];
  assign q_prev = prev_q;
  assign armed  = (arm_cnt_q == ARM_LAST_V);
endmodule

// File: rtl/sar_word_shift.sv
module sar_word_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;
endmodule

// File: rtl/sar_word_commit.sv
module sar_word_commit
  import sar_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  chan_e        chan,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] ch1_o,
  output logic [W-1:0] ch2_o,
  output logic         v1_o,
  output logic         v2_o
);
  logic [W-1:0] ch1_q, ch1_d, ch2_q, ch2_d;
  logic         v1_q, v1_d, v2_q, v2_d;

  always_comb begin
    ch1_d = ch1_q;
    ch2_d = ch2_q;
    v1_d  = 1'b0;
    v2_d  = 1'b0;
    if (commit) begin
      if (chan == CH_ONE) begin
        ch1_d = word_i;
        v1_d  = 1'b1;
      end else begin
        ch2_d = word_i;
        v2_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1_q <= '0;
      ch2_q <= '0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
    end else begin
      ch1_q <= ch1_d;
      ch2_q <= ch2_d;
      v1_q  <= v1_d;
      v2_q  <= v2_d;
    end
  end

  assign ch1_o = ch1_q;
  assign ch2_o = ch2_q;
  assign v1_o  = v1_q;
  assign v2_o  = v2_q;

  // R4: each strobe lasts one cycle, and only one channel strobes at a time
  a_r4_ch1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> !v1_q);
  a_r4_ch2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |=> !v2_q);
  a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1_q && v2_q));
  // R5: a word only changes together with its own strobe
  a_r5_ch1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |-> $stable(ch1_q));
  a_r5_ch2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v2_q |-> $stable(ch2_q));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk_sys,
  input  logic                init_n,
  input  logic                bclk_i,
  input  logic                data_i,
  input  logic                lrck_i,
  input  logic                dbl_speed_i,
  output logic [SAMPLE_W-1:0] ch1_word_o,
  output logic                ch1_valid_o,
  output logic [SAMPLE_W-1:0] ch2_word_o,
  output logic                ch2_valid_o,
  output logic                dbl_speed_o
);
  logic                rst_n_int;
  logic [LINE_CNT-1:0] line_raw, line_q, line_prev;
  logic                lines_armed;
  logic                bclk_rise;
  logic                lrck_edge;
  chan_e               commit_chan;
  logic [SAMPLE_W-1:0] shift_word;

  sar_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk_sys),
    .arst_n  (init_n),
    .rst_n_o (rst_n_int)
  );

  always_comb begin
    line_raw         = '0;
    line_raw[L_BCLK] = bclk_i;
    line_raw[L_DATA] = data_i;
    line_raw[L_LRCK] = lrck_i;
  end

  sar_line_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_sys),
    .rst_n  (rst_n_int),
    .d      (line_raw),
    .q      (line_q),
    .q_prev (line_prev),
    .armed  (lines_armed)
  );

  assign bclk_rise   = lines_armed & line_q[L_BCLK] & ~line_prev[L_BCLK];
  assign lrck_edge   = lines_armed & (line_q[L_LRCK] ^ line_prev[L_LRCK]);
  assign commit_chan = chan_e'(line_prev[L_LRCK]);

  sar_word_shift #(.W(SAMPLE_W)) u_shift (
    .clk      (clk_sys),
    .rst_n    (rst_n_int),
    .shift_en (bclk_rise),
    .bit_i    (line_q[L_DATA]),
    .word_o   (shift_word)
  );

  sar_word_commit #(.W(SAMPLE_W)) u_commit (
    .clk    (clk_sys),
    .rst_n  (rst_n_int),
    .commit (lrck_edge),
    .chan   (commit_chan),
    .word_i (shift_word),
    .ch1_o  (ch1_word_o),
    .ch2_o  (ch2_word_o),
    .v1_o   (ch1_valid_o),
    .v2_o   (ch2_valid_o)
  );

  assign dbl_speed_o = dbl_speed_i;

  // R2: the shifted word moves only after a detected rising bit-clock edge
  a_r2_hold_without_rise: assert property (@(posedge clk_sys) disable iff (!rst_n_int)
    !bclk_rise |=> $stable(shift_word));
  // R7: under initialise, outputs are cleared and silent
  a_r7_zero_in_init: assert property (@(posedge clk_sys)
    !rst_n_int |-> (ch1_word_o == '0 && ch2_word_o == '0 && !ch1_valid_o && !ch2_valid_o));
  // R4: a strobe only follows a word-clock edge
  a_r4_strobe_after_edge: assert property (@(posedge clk_sys) disable iff (!rst_n_int)
    !lrck_edge |=> !(ch1_valid_o || ch2_valid_o));
endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  logic        clk_sys = 1'b0;
  logic        init_n, bclk_i, data_i, lrck_i, dbl_speed_i;
  logic [15:0] ch1_word_o, ch2_word_o;
  logic        ch1_valid_o, ch2_valid_o, dbl_speed_o;

  int          checks = 0;
  int          failures = 0;
  int          half_cyc = 12;
  int          cnt1 = 0;
  int          cnt2 = 0;
  logic        cur_lr = 1'b0;
  logic [15:0] tb_sh = '0;
  logic [15:0] exp1 = '0;
  logic [15:0] exp2 = '0;
  bit          done = 1'b0;

  always #2.5 clk_sys = ~clk_sys;

  serial_audio_rx dut (
    .clk_sys(clk_sys), .init_n(init_n), .bclk_i(bclk_i), .data_i(data_i),
    .lrck_i(lrck_i), .dbl_speed_i(dbl_speed_i),
    .ch1_word_o(ch1_word_o), .ch1_valid_o(ch1_valid_o),
    .ch2_word_o(ch2_word_o), .ch2_valid_o(ch2_valid_o),
    .dbl_speed_o(dbl_speed_o)
  );

  always @(negedge clk_sys) begin
    if (ch1_valid_o) cnt1++;
    if (ch2_valid_o) cnt2++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    @(negedge clk_sys);
    bclk_i = 1'b0;
    data_i = b;
    repeat (half_cyc) @(negedge clk_sys);
    bclk_i = 1'b1;
    if (init_n) tb_sh = {tb_sh[14:0], b};
    if (glitch) begin
      repeat (half_cyc / 2) @(negedge clk_sys);
      data_i = ~b;
      repeat (half_cyc - half_cyc / 2) @(negedge clk_sys);
    end else begin
      repeat (half_cyc) @(negedge clk_sys);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits, input bit glitch);
    for (int i = nbits - 1; i >= 0; i--) drive_bit(w[i], glitch);
  endtask

  task automatic lr_edge(input string req);
    logic        old_lr;
    logic [15:0] word;
    int          c1, c2;
    old_lr = cur_lr;
    word   = tb_sh;
    @(negedge clk_sys);
    c1 = cnt1; c2 = cnt2;
    bclk_i = 1'b0;
    cur_lr = ~cur_lr;
    lrck_i = cur_lr;
    if (old_lr) exp1 = word; else exp2 = word;
    repeat (3) @(negedge clk_sys);
    chk({req, " R4 ch1 strobe"}, {15'd0, ch1_valid_o}, {15'd0, old_lr});
    chk({req, " R4 ch2 strobe"}, {15'd0, ch2_valid_o}, {15'd0, ~old_lr});
    chk({req, " R3 ch1 word"}, ch1_word_o, exp1);
    chk({req, " R3 ch2 word"}, ch2_word_o, exp2);
    @(negedge clk_sys);
    chk({req, " R4 strobe dropped"}, {14'd0, ch1_valid_o, ch2_valid_o}, 16'd0);
    chk({req, " R4 pulse count"}, 16'((cnt1 - c1) + (cnt2 - c2)), 16'd1);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk_sys);
    chk("R7 reset ch1", ch1_word_o, 16'h0000);
    chk("R7 reset ch2", ch2_word_o, 16'h0000);
    chk("R7 reset strobes", {14'd0, ch1_valid_o, ch2_valid_o}, 16'd0);
    @(negedge clk_sys);
    init_n = 1'b1;
    repeat (6) @(negedge clk_sys);
  endtask

  task automatic t_basic();
    lr_edge("R3 first edge");
    send_bits(32'h0000_A5C3, 16, 1'b0);
    lr_edge("R1 ch1 A5C3");
    chk("R1 msb order", ch1_word_o, 16'hA5C3);
    send_bits(32'h0000_3C96, 16, 1'b0);
    lr_edge("R5 ch2 3C96");
    chk("R5 ch1 kept", ch1_word_o, 16'hA5C3);
  endtask

  task automatic t_patterns();
    logic [15:0] pats [6] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'h0000, 16'h1234};
    foreach (pats[k]) begin
      send_bits({16'd0, pats[k]}, 16, 1'b0);
      lr_edge("R1 pattern");
    end
  endtask

  task automatic t_long();
    send_bits(32'h000F_BEEF, 20, 1'b0);
    lr_edge("R6 twenty bits");
    chk("R6 last 16 kept", cur_lr ? ch2_word_o : ch1_word_o, 16'hBEEF);
  endtask

  task automatic t_glitch();
    send_bits(32'h0000_C0DE, 16, 1'b1);
    lr_edge("R2 data change while high");
    chk("R2 word unaffected", cur_lr ? ch2_word_o : ch1_word_o, 16'hC0DE);
  endtask

  task automatic t_dbl();
    dbl_speed_i = 1'b1;
    half_cyc = 6;
    #1;
    chk("R9 pass high", {15'd0, dbl_speed_o}, 16'd1);
    send_bits(32'h0000_5AF0, 16, 1'b0);
    lr_edge("R9 double speed");
    send_bits(32'h0000_0F0F, 16, 1'b0);
    lr_edge("R9 double speed second");
    dbl_speed_i = 1'b0;
    half_cyc = 12;
    #1;
    chk("R9 pass low", {15'd0, dbl_speed_o}, 16'd0);
  endtask

  task automatic t_init_mid();
    int c1, c2;
    send_bits(32'h0000_00FF, 8, 1'b0);
    @(negedge clk_sys);
    init_n = 1'b0;
    #1;
    chk("R7 async clear ch1", ch1_word_o, 16'h0000);
    chk("R7 async clear ch2", ch2_word_o, 16'h0000);
    tb_sh = '0; exp1 = '0; exp2 = '0;
    c1 = cnt1; c2 = cnt2;
    send_bits(32'h0000_FFFF, 16, 1'b0);
    @(negedge clk_sys); lrck_i = ~lrck_i;
    repeat (8) @(negedge clk_sys); lrck_i = ~lrck_i;
    repeat (8) @(negedge clk_sys);
    chk("R7 no strobe in init", 16'((cnt1 - c1) + (cnt2 - c2)), 16'd0);
    chk("R7 ch1 held zero", ch1_word_o, 16'h0000);
    cur_lr = 1'b1;
    lrck_i = 1'b1;
    bclk_i = 1'b1;
    @(negedge clk_sys);
    init_n = 1'b1;
    repeat (10) @(negedge clk_sys);
    chk("R8 no commit at release", 16'((cnt1 - c1) + (cnt2 - c2)), 16'd0);
    send_bits(32'h0000_9E37, 16, 1'b0);
    lr_edge("R8 first word after release");
    chk("R7 partial word cleared", ch1_word_o, 16'h9E37);
  endtask

  initial begin
    init_n = 1'b0; bclk_i = 1'b0; data_i = 1'b0; lrck_i = 1'b0; dbl_speed_i = 1'b0;
    t_reset();
    t_basic();
    t_patterns();
    t_long();
    t_glitch();
    t_dbl();
    t_init_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_sys);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule